// File: doc/BRIEF.md
# ACPI Fixed-Feature and GPE Register Bank

This block is a small memory-mapped I/O register bank holding the ACPI fixed-feature processor control word, a read-triggered C2-entry location, the OS/BIOS command byte and a general-purpose event status/enable pair. It occupies a 16-byte window whose base is a parameter, with a default of I/O address AC00h. It decodes byte offsets inside that window. Every access carries a size code, and a register answers only when the size matches its own width. Any other access is refused with zero read data and a one-cycle error flag.

Several results leave the bank as side-band outputs:

- Reading the C2 location produces a single-cycle request pulse.
- Writing the command byte produces a strobe that carries the byte, and updates an ACPI-enabled flag.
- Each of sixteen event inputs latches a status bit on its rising edge.
- The SCI output is a registered level that is high while any latched status bit has its enable bit set.

Power sequencing and the handling of the command codes belong to logic outside this bank.

Top module: `acpi_ffr_bank`

## Requirements
- R1: The window starts at parameter BASE (default 16'hAC00) and spans 16 bytes. An access outside it gives no response: rd_valid, acc_err, c2_req and cmd_stb all stay low.
- R2: The processor control word is at offset 00h and is accessed as a dword (size 2). It resets to 0. Only bits 2:0 (duty value) and bit 4 (throttle enable) store; all other bits read 0.
- R3: The size code is 0 for byte, 1 for word and 2 for dword. An access whose size differs from the register's width is refused: a read returns 0, a write changes nothing, and acc_err is high for one cycle.
- R4: A byte read at offset 04h returns 0 and raises c2_req for exactly one cycle. A byte write there has no effect and raises no error.
- R5: Byte accesses at offsets 05h and 07h, and any access at offsets 01h–03h or 0Ch–0Fh, read 0 and raise acc_err.
- R6: Offset 06h holds a byte-wide command register that resets to 00h. A byte write stores the byte and pulses cmd_stb for one cycle, with cmd_byte equal to the written value.
- R7: acpi_on resets to 0. A command write of 01h sets it, 02h clears it, and any other code (03h included) leaves it unchanged.
- R8: Event status is a word at offset 08h and event enable is a word at offset 0Ah; both reset to 0. A rising edge on evt_in[i] sets status bit i. Writing 1 to a status bit clears it, writing 0 leaves it alone, and a new edge in the same cycle wins over the clear.
- R9: sci is high exactly when, in the previous cycle, some status bit and its matching enable bit were both set.
- R10: rd_data, rd_valid, acc_err, c2_req, cmd_stb and acpi_on reflect an access on the cycle after the clock edge that samples it. Read data is right-justified, and rd_data is 0 after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 word, 2 dword |
| bus_addr | input | AW (16) | I/O byte address |
| bus_wdata | input | 32 | Right-justified write data |
| evt_in | input | EVT_N (16) | Event inputs, rising-edge sensitive |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | A read hit the window last cycle |
| acc_err | output | 1 | Refused access last cycle |
| c2_req | output | 1 | One-cycle C2 entry request |
| cmd_stb | output | 1 | Command byte written last cycle |
| cmd_byte | output | 8 | Current command byte |
| acpi_on | output | 1 | ACPI-enabled flag |
| sci | output | 1 | SCI interrupt level |

## Verification
Every access-related output is due one clock after the edge that samples the request. The bench drives a request on a falling edge and samples on the next falling edge, which lies after exactly that one capturing edge, and it drops the request at the same moment. An event edge driven before edge E sets status at E. The SCI follows at E+1, so the bench waits two falling edges after raising an event before it checks sci. After a write-one clear, it waits one more falling edge before checking that sci has dropped. The single-cycle nature of c2_req and cmd_stb is checked by sampling once more one cycle later.

// File: rtl/acpi_ffr_pkg.sv
package acpi_ffr_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2} acc_size_e;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_BAD, SEL_PCTL, SEL_C2, SEL_CMD, SEL_GSTS, SEL_GEN
  } reg_sel_e;

  localparam int WIN_BYTES = 16;
  localparam logic [3:0] OFF_PCTL = 4'h0;
  localparam logic [3:0] OFF_C2   = 4'h4;
  localparam logic [3:0] OFF_CMD  = 4'h6;
  localparam logic [3:0] OFF_GSTS = 4'h8;
  localparam logic [3:0] OFF_GEN  = 4'hA;

  localparam logic [7:0] CMD_ON  = 8'h01;
  localparam logic [7:0] CMD_OFF = 8'h02;
endpackage

// File: rtl/acpi_ffr_decode.sv
module acpi_ffr_decode
  import acpi_ffr_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'hAC00
) (
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic          hit,
  output reg_sel_e      sel
);
  logic [AW-1:0] off;

  always_comb begin
    off = addr - BASE;
    hit = valid && (addr >= BASE) && (off < AW'(WIN_BYTES));
    sel = SEL_NONE;
    if (hit) begin
      unique case (off[3:0])
        OFF_PCTL: sel = (size == SZ_DWORD) ? SEL_PCTL : SEL_BAD;
        OFF_C2:   sel = (size == SZ_BYTE)  ? SEL_C2   : SEL_BAD;
        OFF_CMD:  sel = (size == SZ_BYTE)  ? SEL_CMD  : SEL_BAD;
        OFF_GSTS: sel = (size == SZ_WORD)  ? SEL_GSTS : SEL_BAD;
        OFF_GEN:  sel = (size == SZ_WORD)  ? SEL_GEN  : SEL_BAD;
        default:  sel = SEL_BAD;
      endcase
    end
  end
endmodule

// File: rtl/acpi_ffr_gpe.sv
module acpi_ffr_gpe #(
  parameter int EVT_N = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_N-1:0] evt_in,
  input  logic             wr_sts,
  input  logic             wr_en,
  input  logic [EVT_N-1:0] wdata,
  output logic [EVT_N-1:0] sts,
  output logic [EVT_N-1:0] en,
  output logic             sci
);
  logic [EVT_N-1:0] evt_q;
  logic [EVT_N-1:0] rise;
  logic [EVT_N-1:0] clr;

  always_comb begin
    rise = evt_in & ~evt_q;
    clr  = wr_sts ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      sts   <= '0;
      en    <= '0;
      sci   <= 1'b0;
    end else begin
      evt_q <= evt_in;
      sts   <= (sts & ~clr) | rise;
      if (wr_en) en <= wdata;
      sci   <= |(sts & en);
    end
  end
endmodule

// File: rtl/acpi_ffr_cmd.sv
module acpi_ffr_cmd
  import acpi_ffr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] cmd_q,
  output logic       stb,
  output logic       on
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= 8'h00;
      stb   <= 1'b0;
      on    <= 1'b0;
    end else begin
      stb <= wr;
      if (wr) begin
        cmd_q <= wdata;
        if (wdata == CMD_ON)       on <= 1'b1;
        else if (wdata == CMD_OFF) on <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acpi_ffr_bank.sv
module acpi_ffr_bank
  import acpi_ffr_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'hAC00,
  parameter int EVT_N = 16,
  parameter int DUTY_W = 3,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [1:0]       bus_size,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [EVT_N-1:0] evt_in,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             acc_err,
  output logic             c2_req,
  output logic             cmd_stb,
  output logic [7:0]       cmd_byte,
  output logic             acpi_on,
  output logic             sci
);
  localparam int THR_BIT = DUTY_W + 1;
  localparam logic [DW-1:0] PCTL_MASK = DW'((1 << DUTY_W) - 1) | (DW'(1) << THR_BIT);

  logic             hit;
  reg_sel_e         sel;
  logic [DW-1:0]    pctl_q;
  logic [EVT_N-1:0] gpe_sts;
  logic [EVT_N-1:0] gpe_en;
  logic [DW-1:0]    rd_mux;

  acpi_ffr_decode #(.AW(AW), .BASE(BASE)) u_dec (
    .valid(bus_valid), .addr(bus_addr), .size(bus_size), .hit(hit), .sel(sel)
  );

  acpi_ffr_gpe #(.EVT_N(EVT_N)) u_gpe (
    .clk(clk), .rst(rst), .evt_in(evt_in),
    .wr_sts(hit && bus_write && sel == SEL_GSTS),
    .wr_en(hit && bus_write && sel == SEL_GEN),
    .wdata(bus_wdata[EVT_N-1:0]),
    .sts(gpe_sts), .en(gpe_en), .sci(sci)
  );

  acpi_ffr_cmd u_cmd (
    .clk(clk), .rst(rst),
    .wr(hit && bus_write && sel == SEL_CMD),
    .wdata(bus_wdata[7:0]),
    .cmd_q(cmd_byte), .stb(cmd_stb), .on(acpi_on)
  );

  always_comb begin
    unique case (sel)
      SEL_PCTL: rd_mux = pctl_q;
      SEL_CMD:  rd_mux = DW'(cmd_byte);
      SEL_GSTS: rd_mux = DW'(gpe_sts);
      SEL_GEN:  rd_mux = DW'(gpe_en);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pctl_q   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      acc_err  <= 1'b0;
      c2_req   <= 1'b0;
    end else begin
      rd_valid <= hit && !bus_write;
      acc_err  <= hit && (sel == SEL_BAD);
      c2_req   <= hit && !bus_write && (sel == SEL_C2);
      rd_data  <= (hit && !bus_write) ? rd_mux : '0;
      if (hit && bus_write && sel == SEL_PCTL) pctl_q <= bus_wdata & PCTL_MASK;
    end
  end
endmodule

// File: rtl/acpi_ffr_chk.sv
module acpi_ffr_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'hAC00,
  parameter int EVT_N = 16,
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [1:0]       bus_size,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    rd_data,
  input logic             rd_valid,
  input logic             acc_err,
  input logic             c2_req,
  input logic             cmd_stb,
  input logic [7:0]       cmd_byte,
  input logic             acpi_on,
  input logic             sci,
  input logic [EVT_N-1:0] gpe_sts,
  input logic [EVT_N-1:0] gpe_en
);
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> rd_data == '0); // R3
  AST_C2_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    c2_req |-> $past(bus_valid && !bus_write && bus_size == 2'd0 && bus_addr == BASE + AW'(4))); // R4
  AST_CMD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> ($past(bus_valid && bus_write && bus_size == 2'd0 && bus_addr == BASE + AW'(6))
                 && cmd_byte == $past(bus_wdata[7:0]))); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cmd_stb |-> $stable(acpi_on)); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_byte == 8'h01) |-> acpi_on); // R7
  AST_SCI_SOURCE: assert property (@(posedge clk) disable iff (rst)
    sci |-> $past(|(gpe_sts & gpe_en))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_valid) |-> (!rd_valid && !acc_err && !c2_req && !cmd_stb)); // R10
endmodule

bind acpi_ffr_bank acpi_ffr_chk #(.AW(AW), .BASE(BASE), .EVT_N(EVT_N), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .rd_data(rd_data), .rd_valid(rd_valid), .acc_err(acc_err), .c2_req(c2_req),
  .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .acpi_on(acpi_on), .sci(sci),
  .gpe_sts(gpe_sts), .gpe_en(gpe_en)
);

// File: tb/sim_acpi_ffr_bank.sv
module sim_acpi_ffr_bank;
  localparam logic [15:0] BASE = 16'hAC00;
  localparam int NV = 15;
  // {write, size, offset, wdata, expected rd_data, expected acc_err}
  localparam logic [71:0] VEC [NV] = '{
    {1'b1, 2'd2, 4'h0, 32'hFFFF_FFFF, 32'h0,         1'b0}, // R2 write
    {1'b0, 2'd2, 4'h0, 32'h0,         32'h0000_0017, 1'b0}, // R2 masked
    {1'b0, 2'd0, 4'h0, 32'h0,         32'h0,         1'b1}, // R3 byte on dword
    {1'b1, 2'd1, 4'h0, 32'h0000_0012, 32'h0,         1'b1}, // R3 word write
    {1'b0, 2'd2, 4'h0, 32'h0,         32'h0000_0017, 1'b0}, // R3 ignored
    {1'b1, 2'd0, 4'h6, 32'h0000_005A, 32'h0,         1'b0}, // R6
    {1'b0, 2'd0, 4'h6, 32'h0,         32'h0000_005A, 1'b0}, // R6
    {1'b0, 2'd2, 4'h4, 32'h0,         32'h0,         1'b1}, // R3 dword on C2
    {1'b0, 2'd0, 4'h5, 32'h0,         32'h0,         1'b1}, // R5
    {1'b1, 2'd1, 4'hA, 32'h0000_FFFF, 32'h0,         1'b0}, // R8
    {1'b0, 2'd1, 4'hA, 32'h0,         32'h0000_FFFF, 1'b0}, // R8
    {1'b0, 2'd2, 4'h8, 32'h0,         32'h0,         1'b1}, // R3 dword on status
    {1'b0, 2'd0, 4'hC, 32'h0,         32'h0,         1'b1}, // R5
    {1'b1, 2'd2, 4'h0, 32'h0000_0009, 32'h0,         1'b0}, // R2
    {1'b0, 2'd2, 4'h0, 32'h0,         32'h0000_0001, 1'b0}  // R2 bit3 dropped
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [15:0] bus_addr = 16'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [15:0] evt_in = 16'h0;
  logic [31:0] rd_data;
  logic        rd_valid, acc_err, c2_req, cmd_stb, acpi_on, sci;
  logic [7:0]  cmd_byte;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  acpi_ffr_bank u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .evt_in(evt_in), .rd_data(rd_data), .rd_valid(rd_valid), .acc_err(acc_err),
    .c2_req(c2_req), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .acpi_on(acpi_on), .sci(sci)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, req, act, exp);
  endtask

  // drive on a falling edge, sample on the next falling edge
  task automatic access(input bit w, input logic [1:0] sz, input logic [15:0] addr, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_size = sz; bus_addr = addr; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = 32'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_eq("R10 reset rd_valid", 32'(rd_valid), 0);
    chk_eq("R9 reset sci", 32'(sci), 0);
    chk_eq("R7 reset acpi_on", 32'(acpi_on), 0);
    chk_eq("R6 reset cmd_byte", 32'(cmd_byte), 0);

    for (int i = 0; i < NV; i++) begin
      logic [71:0] v;
      v = VEC[i];
      access(v[71], v[70:69], BASE + 16'(v[68:65]), v[64:33]);
      chk_eq($sformatf("R3/R10 vec%0d rd_data", i), rd_data, v[32:1]);
      chk_eq($sformatf("R3 vec%0d acc_err", i), 32'(acc_err), 32'(v[0]));
      chk_eq($sformatf("R10 vec%0d rd_valid", i), 32'(rd_valid), 32'(!v[71]));
    end
    @(negedge clk);
    chk_eq("R3 err one cycle", 32'(acc_err), 0);

    // R1 outside the window
    access(1'b0, 2'd0, BASE + 16'h10, 0);
    chk_eq("R1 no rd_valid", 32'(rd_valid), 0);
    chk_eq("R1 no err", 32'(acc_err), 0);
    access(1'b1, 2'd0, BASE - 16'h2, 32'h01);
    chk_eq("R1 no strobe", 32'(cmd_stb), 0);

    // R4 C2 read
    access(1'b0, 2'd0, BASE + 16'h4, 0);
    chk_eq("R4 c2 pulse", 32'(c2_req), 1);
    chk_eq("R4 c2 data", rd_data, 0);
    chk_eq("R4 c2 no err", 32'(acc_err), 0);
    @(negedge clk);
    chk_eq("R4 c2 single", 32'(c2_req), 0);
    access(1'b1, 2'd0, BASE + 16'h4, 32'hFF);
    chk_eq("R4 write no c2", 32'(c2_req), 0);
    chk_eq("R4 write no err", 32'(acc_err), 0);

    // R5 reserved 07h
    access(1'b0, 2'd0, BASE + 16'h7, 0);
    chk_eq("R5 rsvd 07 err", 32'(acc_err), 1);
    chk_eq("R5 rsvd 07 data", rd_data, 0);

    // R6 / R7 command
    access(1'b1, 2'd0, BASE + 16'h6, 32'h01);
    chk_eq("R6 stb", 32'(cmd_stb), 1);
    chk_eq("R6 byte", 32'(cmd_byte), 32'h01);
    chk_eq("R7 set", 32'(acpi_on), 1);
    @(negedge clk);
    chk_eq("R6 stb single", 32'(cmd_stb), 0);
    access(1'b1, 2'd0, BASE + 16'h6, 32'h03);
    chk_eq("R6 byte 03", 32'(cmd_byte), 32'h03);
    chk_eq("R7 03 keeps", 32'(acpi_on), 1);
    access(1'b1, 2'd0, BASE + 16'h6, 32'h02);
    chk_eq("R7 clear", 32'(acpi_on), 0);
    access(1'b1, 2'd2, BASE + 16'h6, 32'h01);
    chk_eq("R3 wide cmd no stb", 32'(cmd_stb), 0);
    chk_eq("R3 wide cmd flag", 32'(acpi_on), 0);
    access(1'b0, 2'd0, BASE + 16'h6, 0);
    chk_eq("R3 wide cmd ignored", rd_data, 32'h02);

    // R8 / R9 events
    access(1'b1, 2'd1, BASE + 16'hA, 32'h0008);
    @(negedge clk); evt_in[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk_eq("R9 unenabled no sci", 32'(sci), 0);
    access(1'b0, 2'd1, BASE + 16'h8, 0);
    chk_eq("R8 status bit5", rd_data, 32'h0020);
    evt_in[3] = 1'b1;
    @(negedge clk);
    chk_eq("R9 sci lags status", 32'(sci), 0);
    @(negedge clk);
    chk_eq("R9 sci high", 32'(sci), 1);
    access(1'b1, 2'd1, BASE + 16'h8, 32'h0008);
    @(negedge clk);
    chk_eq("R9 sci drops", 32'(sci), 0);
    access(1'b0, 2'd1, BASE + 16'h8, 0);
    chk_eq("R8 w1c keeps bit5, held level no reset", rd_data, 32'h0020);
    evt_in[3] = 1'b0;
    @(negedge clk); evt_in[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk_eq("R8 new edge sets", 32'(sci), 1);
    // clear and new edge in the same cycle: set wins
    evt_in[3] = 1'b0;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_size = 2'd1;
    bus_addr = BASE + 16'h8; bus_wdata = 32'h0028; evt_in[3] = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    access(1'b0, 2'd1, BASE + 16'h8, 0);
    chk_eq("R8 set wins over clear", rd_data, 32'h0008);

    // reset mid-run
    @(negedge clk); rst = 1'b1; evt_in = 16'h0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk_eq("R9 reset sci", 32'(sci), 0);
    access(1'b0, 2'd2, BASE, 0);
    chk_eq("R2 reset pctl", rd_data, 0);
    access(1'b0, 2'd1, BASE + 16'hA, 0);
    chk_eq("R8 reset enable", rd_data, 0);
    access(1'b0, 2'd0, BASE + 16'h6, 0);
    chk_eq("R6 reset cmd", rd_data, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule